// File: doc/BRIEF.md
# PHY Register Handshake Sequencer

This block gives a host a plain request port for reading and writing 16-bit registers inside a PHY that has no memory-mapped register path. The PHY side is a packed control word: a 16-bit field that carries an address or data word, with four strobes above it (capture address, capture data, write, read). A status word comes back: 16 bits of read data plus a single acknowledge bit. Every strobe is a four-phase handshake. The strobe rises, the sequencer waits for acknowledge high, the strobe falls, and the sequencer waits for acknowledge low.

An access always begins by loading the address. A write then loads the data word and fires the write strobe. A read fires the read strobe and captures the returned data. Each acknowledge wait checks the line at entry and then once every `POLL_GAP` cycles, for at most `POLL_LIMIT` checks. If the expected level never shows, the access is abandoned, the control word is cleared and a timeout is reported. The host side is a valid/ready request channel. `req_ready` is high only while the sequencer is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low, the request inputs are ignored and the host must hold or retry. The response has no back-pressure. `rsp_valid` is a one-cycle pulse, and the host must take `rsp_timeout` and `rsp_rdata` in that cycle.

Top module: `phy_reg_seq`

## Requirements
- R1: `phy_ctrl` places the field in bits 15:0, capture-address in bit 16, capture-data in bit 17, write in bit 18 and read in bit 19; at most one of bits 19:16 is high at any time. In `phy_stat`, bits 15:0 are read data and bit 16 is acknowledge.
- R2: `req_ready` is high only in idle. A request is taken when `req_valid` and `req_ready` are both high. A request presented while busy has no effect, and no strobe is driven while idle.
- R3: Every access starts with one cycle that drives the address on the field with no strobe. Capture-address is then raised with the address until acknowledge is 1. The address stays on the field with no strobe until acknowledge is 0.
- R4: A write then drives the data word for one cycle with no strobe. It raises capture-data with the data held until acknowledge is 1, then drops it until acknowledge is 0. It then raises write with a zero field until acknowledge is 1, drives the data word with no strobe until acknowledge is 0, and ends with the control word at zero.
- R5: A read raises the read strobe with a zero field until acknowledge is 1, then captures status bits 15:0. The control word stays zero until acknowledge is 0, and then the access completes.
- R6: Each acknowledge wait samples in its first cycle and every `POLL_GAP` cycles after that, for at most `POLL_LIMIT` samples. With an immediate one-cycle acknowledge, every wait lasts `POLL_GAP`+1 cycles.
- R7: When no sample matches, the sequencer spends one cycle with the control word at zero. In that cycle it raises `rsp_valid` with `rsp_timeout`, then returns to idle, ready for the next request. A timeout in the first wait ends the access `POLL_LIMIT`-1 gaps plus 3 cycles after acceptance.
- R8: `rsp_rdata` changes only in the `rsp_valid` cycle of a read that completed without timeout. Writes and timed-out accesses leave it unchanged.
- R9: `rsp_valid` is high for exactly one cycle per accepted request. `rsp_timeout` is low whenever `rsp_valid` is low.
- R10: After reset, `phy_ctrl` is 0, `req_ready` is 1, and `rsp_valid`, `rsp_timeout` and `rsp_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DATA_W | PHY register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Access aborted on an acknowledge timeout |
| rsp_rdata | output | DATA_W | Last successfully read data |
| phy_ctrl | output | DATA_W+4 | Control word: strobes over the address/data field |
| phy_stat | input | DATA_W+1 | Status word: acknowledge over the read data |

## Verification
The bench builds the block with `POLL_LIMIT` = 4 and `POLL_GAP` = 3. Under these settings a timed-out wait lasts only ten cycles, and a full write finishes in 27 cycles, so exact cycle counts of normal and aborted accesses can be compared with values worked out from the requirements. A bench PHY model can acknowledge normally, never acknowledge, or hold acknowledge high. These modes put a timeout in the high-level wait and in the low-level wait of the address phase, and the bench checks recovery afterwards.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  // strobe positions inside the nibble above the field
  localparam int unsigned STB_CAPA = 0;
  localparam int unsigned STB_CAPD = 1;
  localparam int unsigned STB_WR   = 2;
  localparam int unsigned STB_RD   = 3;
  localparam int unsigned STB_N    = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_SET,
    ST_A_HI,
    ST_A_LO,
    ST_D_SET,
    ST_D_HI,
    ST_D_LO,
    ST_W_HI,
    ST_W_LO,
    ST_R_HI,
    ST_R_LO,
    ST_FIN
  } seq_state_e;

  function automatic logic is_wait(input seq_state_e s);
    return (s == ST_A_HI) || (s == ST_A_LO) || (s == ST_D_HI) || (s == ST_D_LO) ||
           (s == ST_W_HI) || (s == ST_W_LO) || (s == ST_R_HI) || (s == ST_R_LO);
  endfunction

  function automatic logic wait_level(input seq_state_e s);
    return (s == ST_A_HI) || (s == ST_D_HI) || (s == ST_W_HI) || (s == ST_R_HI);
  endfunction

endpackage

// File: rtl/phy_seq_poll.sv
module phy_seq_poll #(
  parameter int unsigned POLL_LIMIT = 10,
  parameter int unsigned POLL_GAP   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic ack,
  input  logic expect_lvl,
  output logic hit,
  output logic expire
);
  localparam int unsigned GAP_W = (POLL_GAP   > 1) ? $clog2(POLL_GAP)   : 1;
  localparam int unsigned CNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(POLL_GAP - 1);
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(POLL_LIMIT - 1);

  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] samp_q;
  logic             sample_now;

  assign sample_now = active && (gap_q == '0);
  assign hit        = sample_now && (ack == expect_lvl);
  assign expire     = sample_now && (ack != expect_lvl) && (samp_q == SAMP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      samp_q <= '0;
    end else if (restart || !active) begin
      gap_q  <= '0;
      samp_q <= '0;
    end else if (gap_q == GAP_LAST) begin
      gap_q  <= '0;
    end else begin
      if (gap_q == '0) samp_q <= samp_q + 1'b1;
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hit,
  input  logic              expire,
  input  logic [DATA_W-1:0] stat_data,
  output seq_state_e        state_q,
  output logic              restart,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              err_q,
  output logic [DATA_W-1:0] rdata_q
);
  seq_state_e        state_d;
  logic              wr_q;
  logic [DATA_W-1:0] shadow_q;

  always_comb begin
    state_d = state_q;
    if (expire) begin
      state_d = ST_FIN;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (req_fire) state_d = ST_A_SET;
        ST_A_SET: state_d = ST_A_HI;
        ST_A_HI:  if (hit) state_d = ST_A_LO;
        ST_A_LO:  if (hit) state_d = wr_q ? ST_D_SET : ST_R_HI;
        ST_D_SET: state_d = ST_D_HI;
        ST_D_HI:  if (hit) state_d = ST_D_LO;
        ST_D_LO:  if (hit) state_d = ST_W_HI;
        ST_W_HI:  if (hit) state_d = ST_W_LO;
        ST_W_LO:  if (hit) state_d = ST_FIN;
        ST_R_HI:  if (hit) state_d = ST_R_LO;
        ST_R_LO:  if (hit) state_d = ST_FIN;
        ST_FIN:   state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      err_q    <= 1'b0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_fire) begin
        wr_q   <= req_write;
        addr_q <= req_addr;
        data_q <= req_wdata;
        err_q  <= 1'b0;
      end
      if (expire) err_q <= 1'b1;
      if (state_q == ST_R_HI && hit) shadow_q <= stat_data;
      if (state_q == ST_R_LO && hit) rdata_q  <= shadow_q;
    end
  end
endmodule

// File: rtl/phy_seq_drive.sv
module phy_seq_drive
  import phy_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  seq_state_e              state,
  input  logic [DATA_W-1:0]       addr,
  input  logic [DATA_W-1:0]       data,
  output logic [DATA_W+STB_N-1:0] ctrl
);
  logic [STB_N-1:0]  stb;
  logic [DATA_W-1:0] field;

  always_comb begin
    stb   = '0;
    field = '0;
    unique case (state)
      ST_A_SET, ST_A_LO:         field = addr;
      ST_A_HI: begin
        field         = addr;
        stb[STB_CAPA] = 1'b1;
      end
      ST_D_SET, ST_D_LO, ST_W_LO: field = data;
      ST_D_HI: begin
        field         = data;
        stb[STB_CAPD] = 1'b1;
      end
      ST_W_HI: stb[STB_WR] = 1'b1;
      ST_R_HI: stb[STB_RD] = 1'b1;
      default: begin
        stb   = '0;
        field = '0;
      end
    endcase
  end

  assign ctrl = {stb, field};
endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned POLL_LIMIT = 10,
  parameter int unsigned POLL_GAP   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_timeout,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W+3:0] phy_ctrl,
  input  logic [DATA_W:0]   phy_stat
);
  seq_state_e        state;
  logic              restart, hit, expire, err;
  logic [DATA_W-1:0] addr, data;

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_FIN);
  assign rsp_timeout = rsp_valid && err;

  phy_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_valid && req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .hit       (hit),
    .expire    (expire),
    .stat_data (phy_stat[DATA_W-1:0]),
    .state_q   (state),
    .restart   (restart),
    .addr_q    (addr),
    .data_q    (data),
    .err_q     (err),
    .rdata_q   (rsp_rdata)
  );

  phy_seq_poll #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_poll (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .active     (is_wait(state)),
    .ack        (phy_stat[DATA_W]),
    .expect_lvl (wait_level(state)),
    .hit        (hit),
    .expire     (expire)
  );

  phy_seq_drive #(.DATA_W(DATA_W)) u_drive (
    .state (state),
    .addr  (addr),
    .data  (data),
    .ctrl  (phy_ctrl)
  );
endmodule

// File: rtl/phy_reg_seq_chk.sv
module phy_reg_seq_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_timeout,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W+3:0] phy_ctrl
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl[DATA_W+3:DATA_W])); // R1
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (phy_ctrl[DATA_W+3:DATA_W] == 4'b0000)); // R2
  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> (phy_ctrl == '0)); // R7
  AST_TIMEOUT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |=> req_ready); // R7
  AST_RDATA_ONLY_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> (rsp_valid && !rsp_timeout)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> rsp_valid); // R9
endmodule

bind phy_reg_seq phy_reg_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_timeout (rsp_timeout),
  .rsp_rdata   (rsp_rdata),
  .phy_ctrl    (phy_ctrl)
);

// File: tb/phy_reg_seq_bench.sv
module phy_reg_seq_bench;
  localparam int DW = 16;
  localparam int L  = 4;
  localparam int G  = 3;
  localparam int CYC_TO_HI = 2 + (L - 1) * G + 1;  // timeout in first wait
  localparam int CYC_TO_LO = CYC_TO_HI + 1;        // timeout in second wait
  localparam int CYC_RD    = 2 + 4 * (G + 1);
  localparam int CYC_WR    = 3 + 6 * (G + 1);

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  mode;   // 0 normal, 1 never ack, 2 ack stuck high
    logic        to;
    logic [15:0] rd;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b1, 16'h0003, 16'hA5C3, 2'd0, 1'b0, 16'h0000},
    '{1'b1, 16'h000C, 16'h1234, 2'd0, 1'b0, 16'h0000},
    '{1'b0, 16'h0003, 16'h0000, 2'd0, 1'b0, 16'hA5C3},
    '{1'b0, 16'h000C, 16'h0000, 2'd0, 1'b0, 16'h1234},
    '{1'b1, 16'h0003, 16'hFFFF, 2'd1, 1'b1, 16'h1234},
    '{1'b0, 16'h0003, 16'h0000, 2'd0, 1'b0, 16'hA5C3},
    '{1'b0, 16'h000C, 16'h0000, 2'd2, 1'b1, 16'hA5C3},
    '{1'b1, 16'h0007, 16'h0BAD, 2'd2, 1'b1, 16'hA5C3},
    '{1'b1, 16'h0007, 16'h8001, 2'd0, 1'b0, 16'hA5C3},
    '{1'b0, 16'h0007, 16'h0000, 2'd0, 1'b0, 16'h8001},
    '{1'b0, 16'h0000, 16'h0000, 2'd0, 1'b0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [DW-1:0] req_addr = '0, req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_timeout;
  logic [DW-1:0] rsp_rdata;
  logic [DW+3:0] phy_ctrl;
  logic [DW:0]   phy_stat;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  phy_reg_seq #(.DATA_W(DW), .POLL_LIMIT(L), .POLL_GAP(G)) u_phy_reg_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .phy_ctrl(phy_ctrl), .phy_stat(phy_stat));

  // PHY model
  logic [1:0]    phy_mode = 2'd0;
  logic          ack_r;
  logic [DW-1:0] m_addr, m_data, rd_r;
  logic [DW-1:0] mem [16];
  assign phy_stat = {ack_r, rd_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_r <= 1'b0; m_addr <= '0; m_data <= '0; rd_r <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      case (phy_mode)
        2'd1:    ack_r <= 1'b0;
        2'd2:    ack_r <= 1'b1;
        default: ack_r <= |phy_ctrl[19:16];
      endcase
      if (phy_ctrl[16] && !ack_r) m_addr <= phy_ctrl[15:0];
      if (phy_ctrl[17] && !ack_r) m_data <= phy_ctrl[15:0];
      if (phy_ctrl[18] && !ack_r) mem[m_addr[3:0]] <= m_data;
      if (phy_ctrl[19]) rd_r <= mem[m_addr[3:0]];
    end
  end

  // protocol monitor on the control word
  logic [DW+3:0] prev_ctrl = '0;
  logic [DW-1:0] cur_addr = '0, cur_data = '0;
  logic [1:0]    rlog [64];
  int            log_n = 0, mon_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!$onehot0(phy_ctrl[19:16])) mon_err++;
      if (phy_ctrl[16] && !prev_ctrl[16]) begin
        if (prev_ctrl[15:0] != cur_addr || phy_ctrl[15:0] != cur_addr) mon_err++;
        rlog[log_n % 64] = 2'd0; log_n++;
      end
      if (phy_ctrl[17] && !prev_ctrl[17]) begin
        if (prev_ctrl[15:0] != cur_data || phy_ctrl[15:0] != cur_data) mon_err++;
        rlog[log_n % 64] = 2'd1; log_n++;
      end
      if (phy_ctrl[18] && !prev_ctrl[18]) begin
        if (phy_ctrl[15:0] != '0) mon_err++;
        rlog[log_n % 64] = 2'd2; log_n++;
      end
      if (phy_ctrl[19] && !prev_ctrl[19]) begin
        if (phy_ctrl[15:0] != '0) mon_err++;
        rlog[log_n % 64] = 2'd3; log_n++;
      end
      if (!phy_ctrl[16] && prev_ctrl[16] && phy_ctrl[15:0] != cur_addr) mon_err++;
      prev_ctrl = phy_ctrl;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // one access; returns negedges from acceptance to done
  task automatic run(input logic wr, input logic [15:0] a, input logic [15:0] d,
                     input logic [1:0] mode, output int cyc, output logic to,
                     output int seq_sig, output int seq_n);
    int start_n, err0;
    @(negedge clk);
    phy_mode = mode; cur_addr = a; cur_data = d;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    start_n = log_n; err0 = mon_err;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 500) begin
      chk(!rsp_timeout, "R9 flag without done", rsp_timeout, 0);
      @(negedge clk); cyc++;
    end
    to = rsp_timeout;
    if (to) chk(phy_ctrl == '0, "R7 control cleared on timeout", phy_ctrl, 0);
    seq_sig = 0; seq_n = log_n - start_n;
    for (int k = start_n; k < log_n; k++) seq_sig = seq_sig * 4 + int'(rlog[k % 64]);
    chk(mon_err == err0, "R1 R3 R4 field/strobe shape", mon_err - err0, 0);
    @(negedge clk);
    chk(!rsp_valid, "R9 done is one cycle", rsp_valid, 0);
    chk(req_ready, "R7 back to idle", req_ready, 1);
  endtask

  initial begin
    int cyc, sig, sn, expc;
    logic to;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(phy_ctrl == '0, "R10 ctrl at reset", phy_ctrl, 0);
    chk(req_ready == 1'b1, "R10 ready at reset", req_ready, 1);
    chk(!rsp_valid && !rsp_timeout, "R10 done/flag at reset", {rsp_valid, rsp_timeout}, 0);
    chk(rsp_rdata == '0, "R10 rdata at reset", rsp_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < 11; i++) begin
      run(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].mode, cyc, to, sig, sn);
      chk(to == VEC[i].to, $sformatf("R7 timeout flag vec %0d", i), to, VEC[i].to);
      chk(rsp_rdata == VEC[i].rd, $sformatf("R5 R8 rdata vec %0d", i), rsp_rdata, VEC[i].rd);
      if (VEC[i].mode == 2'd1)      expc = CYC_TO_HI;
      else if (VEC[i].mode == 2'd2) expc = CYC_TO_LO;
      else                          expc = VEC[i].wr ? CYC_WR : CYC_RD;
      chk(cyc == expc, $sformatf("R6 access length vec %0d", i), cyc, expc);
      if (VEC[i].mode == 2'd0) begin
        chk(sig == (VEC[i].wr ? 6 : 3) && sn == (VEC[i].wr ? 3 : 2),
            $sformatf("R3 R4 R5 strobe order vec %0d", i), sig, VEC[i].wr ? 6 : 3);
      end else begin
        chk(sn == 1, $sformatf("R7 no strobe after abort vec %0d", i), sn, 1);
      end
    end

    // R2: a request while busy is ignored
    @(negedge clk);
    phy_mode = 2'd0; cur_addr = 16'h0005; cur_data = 16'h1111;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0005; req_wdata = 16'h1111;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!req_ready, "R2 not ready while busy", req_ready, 0);
    req_valid = 1'b1; req_addr = 16'h0006; req_wdata = 16'h2222;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R2 single completion", rsp_valid, 0);
    run(1'b0, 16'h0006, 16'h0000, 2'd0, cyc, to, sig, sn);
    chk(rsp_rdata == 16'h0000, "R2 busy request had no effect", rsp_rdata, 0);
    run(1'b0, 16'h0005, 16'h0000, 2'd0, cyc, to, sig, sn);
    chk(rsp_rdata == 16'h1111, "R2 first request completed", rsp_rdata, 16'h1111);

    // R8: timed-out read leaves data alone
    run(1'b0, 16'h0005, 16'h0000, 2'd1, cyc, to, sig, sn);
    chk(to && rsp_rdata == 16'h1111, "R8 rdata held on timeout", rsp_rdata, 16'h1111);

    summary();
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      summary();
    end
  end
endmodule